// File: doc/BRIEF.md
# Per-Class Cache Bank Mapper

This block sits beside a private-cache controller and, for every request that misses there, works out which shared-cache banks the request should visit. Each request carries a line address and a page caching class (thread-local, process-local or global). The class picks one of three table entries. Each entry holds two descriptors. The active one serves lookups. The shadow one can be refilled by software with a new configuration.

A descriptor consists of a hash seed, a bank-ID array for the third cache level, a bank-ID array for the fourth cache level, and a flag that says whether the fourth level is in use. The line address is XOR-folded down to a slot index and mixed with the seed. That single index picks one element from each array. The registered response names the third-level bank, and then either a fourth-level bank or a flag that sends a third-level miss straight to memory.

Software reaches every field of every descriptor through a small read/write port, so the whole table can be saved and restored on a context switch. A per-class swap input exchanges the active and shadow roles once a migration has finished.

Top module: `class_bank_mapper`

## Requirements
- R1: After reset, `rsp_valid` is 0 and every table field reads back as 0. A lookup made before any table write returns third-level bank 0 with `rsp_bypass` set.
- R2: `rsp_valid` is 1 in exactly the cycle after a cycle with `req_valid` high, and 0 otherwise.
- R3: The slot index is built by splitting `req_line_addr` into 3-bit chunks, starting from the least significant bit and zero-padding the top chunk. All chunks are XORed together, and the result is XORed with the active descriptor's seed.
- R4: `rsp_l3_bank` is the active descriptor's third-level array element at the slot index. The array may hold the same bank ID in several slots.
- R5: When the active descriptor's fourth-level flag is 1, `rsp_l4_bank` is that array's element at the slot index and `rsp_bypass` is 0. When the flag is 0, `rsp_bypass` is 1 and `rsp_l4_bank` is 0.
- R6: `req_class` codes select the entry: 0 is thread-local, 1 is process-local, 2 is global, and 3 is treated as global.
- R7: The `cfg_addr` layout is {class[7:6], role[5], field[4:3], slot[2:0]}. Role 0 is active and role 1 is shadow. Field 0 is the third-level array and field 1 is the fourth-level array, each holding a bank ID per slot. Field 2 is control: the seed in bits [2:0] and the fourth-level flag in bit 3, with the slot ignored and the upper bits reading 0. Field 3, or class 3, reads 0 and ignores writes.
- R8: Writes to the shadow role do not change any lookup result.
- R9: A `swap_valid` pulse on `swap_class` exchanges that class's active and shadow roles. Both reads and lookups see the exchange. Other classes are untouched.
- R10: A lookup in the same cycle as a table write or a swap uses the table as it stood before that cycle. The change is visible from the next cycle.
- R11: `cfg_rdata` is combinational from `cfg_addr` and returns the last value written to that field and role.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Miss request present |
| req_class | input | 2 | Page caching class of the request |
| req_line_addr | input | LINE_ADDR_W (34) | Line address of the request |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 8 | Table field address {class, role, field, slot} |
| cfg_wdata | input | BANK_W (6) | Table write data |
| cfg_rdata | output | BANK_W (6) | Table read data for `cfg_addr` |
| swap_valid | input | 1 | Exchange active and shadow roles |
| swap_class | input | 2 | Class whose roles are exchanged |
| rsp_valid | output | 1 | Response present |
| rsp_l3_bank | output | BANK_W (6) | Third-level bank for the request |
| rsp_l4_bank | output | BANK_W (6) | Fourth-level bank (0 when bypassing) |
| rsp_bypass | output | 1 | Third-level miss goes directly to memory |

## Verification
The lookup is tried with several kinds of address:
- Addresses with a single bit set in different chunks, which shows whether each chunk reaches the fold.
- Dense random-looking addresses under non-zero seeds, which separates a correct fold from one that drops the seed or the padded top chunk.

The L3 arrays are filled in three ways:
- Distinct bank IDs, which reveals a wrong slot.
- Duplicate bank IDs, which shows that the array is treated as a table rather than a set.
- A class-specific fill, which exposes a wrong class selection, including the alias for code 3.

A final group of scenarios writes to a shadow descriptor, swaps roles, and issues writes and swaps in the same cycle as a lookup. These distinguish correct role bookkeeping from updates that take effect too early or land on the wrong descriptor.

// File: rtl/bmap_pkg.sv
// Shared encodings for the per-class bank mapper.
package bmap_pkg;
    // Page caching classes carried by a request; code 3 aliases global.
    typedef enum logic [1:0] {
        CLS_THREAD  = 2'd0,
        CLS_PROCESS = 2'd1,
        CLS_GLOBAL  = 2'd2,
        CLS_ALIAS   = 2'd3
    } page_class_e;

    // Field selector inside a configuration address.
    typedef enum logic [1:0] {
        FLD_L3   = 2'd0,
        FLD_L4   = 2'd1,
        FLD_CTRL = 2'd2,
        FLD_NONE = 2'd3
    } cfg_field_e;

    localparam int NUM_CLASSES = 3;
endpackage

// File: rtl/bmap_hash.sv
// Folds a line address into a slot index by XORing fixed-width chunks
// together with a seed. Assumes LINE_ADDR_W >= 1 and IDX_W >= 1; the top
// chunk is zero-padded. Purely combinational.
module bmap_hash #(
    parameter int LINE_ADDR_W = 34,
    parameter int IDX_W       = 3
) (
    input  logic [LINE_ADDR_W-1:0] line_addr,
    input  logic [IDX_W-1:0]       seed,
    output logic [IDX_W-1:0]       idx
);
    localparam int CHUNKS = (LINE_ADDR_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W  = CHUNKS * IDX_W;

    logic [PAD_W-1:0] padded;

    // Zero-pad the address then XOR all chunks and the seed.
    always_comb begin
        padded = '0;
        padded[LINE_ADDR_W-1:0] = line_addr;
        idx = seed;
        for (int c = 0; c < CHUNKS; c++) begin
            idx = idx ^ padded[c*IDX_W +: IDX_W];
        end
    end
endmodule

// File: rtl/bmap_entry.sv
// One class entry: two physical descriptors with a role bit naming the
// active one. Writes and reads address descriptors by role (0 active,
// 1 shadow). A swap flips the role bit; a write in the same cycle as a
// swap lands on the role as it was before the swap.
module bmap_entry #(
    parameter int N_SLOTS = 8,
    parameter int BANK_W  = 6,
    parameter int IDX_W   = $clog2(N_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_role,
    input  logic [1:0]        wr_field,
    input  logic [IDX_W-1:0]  wr_slot,
    input  logic [BANK_W-1:0] wr_data,
    input  logic              swap,
    input  logic              rd_role,
    input  logic [1:0]        rd_field,
    input  logic [IDX_W-1:0]  rd_slot,
    output logic [BANK_W-1:0] rd_data,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic [IDX_W-1:0]  lk_seed,
    output logic [BANK_W-1:0] lk_l3,
    output logic [BANK_W-1:0] lk_l4,
    output logic              lk_l4_valid
);
    import bmap_pkg::*;

    logic [BANK_W-1:0] l3_q   [2][N_SLOTS];
    logic [BANK_W-1:0] l4_q   [2][N_SLOTS];
    logic [IDX_W-1:0]  seed_q [2];
    logic              l4v_q  [2];
    logic              act_q;
    logic              wr_phys;
    logic              rd_phys;

    assign wr_phys = act_q ^ wr_role;
    assign rd_phys = act_q ^ rd_role;

    // Descriptor storage and role bit update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            for (int p = 0; p < 2; p++) begin
                seed_q[p] <= '0;
                l4v_q[p]  <= 1'b0;
                for (int s = 0; s < N_SLOTS; s++) begin
                    l3_q[p][s] <= '0;
                    l4_q[p][s] <= '0;
                end
            end
        end else begin
            if (wr_en) begin
                case (wr_field)
                    FLD_L3:   l3_q[wr_phys][wr_slot] <= wr_data;
                    FLD_L4:   l4_q[wr_phys][wr_slot] <= wr_data;
                    FLD_CTRL: begin
                        seed_q[wr_phys] <= wr_data[IDX_W-1:0];
                        l4v_q[wr_phys]  <= wr_data[IDX_W];
                    end
                    default: ;
                endcase
            end
            if (swap) begin
                act_q <= ~act_q;
            end
        end
    end

    // Software read-back mux by role and field.
    always_comb begin
        rd_data = '0;
        case (rd_field)
            FLD_L3: rd_data = l3_q[rd_phys][rd_slot];
            FLD_L4: rd_data = l4_q[rd_phys][rd_slot];
            FLD_CTRL: begin
                rd_data[IDX_W-1:0] = seed_q[rd_phys];
                rd_data[IDX_W]     = l4v_q[rd_phys];
            end
            default: rd_data = '0;
        endcase
    end

    // Lookup side always reads the active descriptor.
    always_comb begin
        lk_seed     = seed_q[act_q];
        lk_l3       = l3_q[act_q][lk_idx];
        lk_l4       = l4_q[act_q][lk_idx];
        lk_l4_valid = l4v_q[act_q];
    end
endmodule

// File: rtl/class_bank_mapper.sv
// Top of the per-class bank mapper. Selects a class entry, hashes the
// line address with that entry's active seed, picks L3/L4 banks, and
// registers the result one cycle after a valid request. Assumes
// BANK_W >= IDX_W + 1 so a control word fits in the data path.
module class_bank_mapper #(
    parameter int LINE_ADDR_W = 34,
    parameter int N_SLOTS     = 8,
    parameter int BANK_W      = 6,
    parameter int IDX_W       = $clog2(N_SLOTS),
    parameter int CFG_AW      = IDX_W + 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [1:0]             req_class,
    input  logic [LINE_ADDR_W-1:0] req_line_addr,
    input  logic                   cfg_we,
    input  logic [CFG_AW-1:0]      cfg_addr,
    input  logic [BANK_W-1:0]      cfg_wdata,
    output logic [BANK_W-1:0]      cfg_rdata,
    input  logic                   swap_valid,
    input  logic [1:0]             swap_class,
    output logic                   rsp_valid,
    output logic [BANK_W-1:0]      rsp_l3_bank,
    output logic [BANK_W-1:0]      rsp_l4_bank,
    output logic                   rsp_bypass
);
    import bmap_pkg::*;

    logic [IDX_W-1:0] cfg_slot;
    logic [1:0]       cfg_field;
    logic             cfg_role;
    logic [1:0]       cfg_cls;

    assign cfg_slot  = cfg_addr[IDX_W-1:0];
    assign cfg_field = cfg_addr[IDX_W+1:IDX_W];
    assign cfg_role  = cfg_addr[IDX_W+2];
    assign cfg_cls   = cfg_addr[IDX_W+4:IDX_W+3];

    logic [BANK_W-1:0] ent_rd   [NUM_CLASSES];
    logic [IDX_W-1:0]  ent_seed [NUM_CLASSES];
    logic [BANK_W-1:0] ent_l3   [NUM_CLASSES];
    logic [BANK_W-1:0] ent_l4   [NUM_CLASSES];
    logic              ent_l4v  [NUM_CLASSES];
    logic [IDX_W-1:0]  lk_idx;

    genvar c;
    generate
        for (c = 0; c < NUM_CLASSES; c++) begin : g_entry
            bmap_entry #(
                .N_SLOTS(N_SLOTS),
                .BANK_W (BANK_W),
                .IDX_W  (IDX_W)
            ) u_entry (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_en      (cfg_we && (cfg_cls == 2'(c))),
                .wr_role    (cfg_role),
                .wr_field   (cfg_field),
                .wr_slot    (cfg_slot),
                .wr_data    (cfg_wdata),
                .swap       (swap_valid && (swap_class == 2'(c))),
                .rd_role    (cfg_role),
                .rd_field   (cfg_field),
                .rd_slot    (cfg_slot),
                .rd_data    (ent_rd[c]),
                .lk_idx     (lk_idx),
                .lk_seed    (ent_seed[c]),
                .lk_l3      (ent_l3[c]),
                .lk_l4      (ent_l4[c]),
                .lk_l4_valid(ent_l4v[c])
            );
        end
    endgenerate

    // Software read mux across class entries; class code 3 reads zero.
    always_comb begin
        case (cfg_cls)
            2'd0:    cfg_rdata = ent_rd[0];
            2'd1:    cfg_rdata = ent_rd[1];
            2'd2:    cfg_rdata = ent_rd[2];
            default: cfg_rdata = '0;
        endcase
    end

    logic [IDX_W-1:0]  sel_seed;
    logic [BANK_W-1:0] sel_l3;
    logic [BANK_W-1:0] sel_l4;
    logic              sel_l4v;

    // Request class to entry select; alias code maps onto global.
    always_comb begin
        case (req_class)
            CLS_THREAD: begin
                sel_seed = ent_seed[0]; sel_l3 = ent_l3[0];
                sel_l4   = ent_l4[0];   sel_l4v = ent_l4v[0];
            end
            CLS_PROCESS: begin
                sel_seed = ent_seed[1]; sel_l3 = ent_l3[1];
                sel_l4   = ent_l4[1];   sel_l4v = ent_l4v[1];
            end
            default: begin
                sel_seed = ent_seed[2]; sel_l3 = ent_l3[2];
                sel_l4   = ent_l4[2];   sel_l4v = ent_l4v[2];
            end
        endcase
    end

    bmap_hash #(
        .LINE_ADDR_W(LINE_ADDR_W),
        .IDX_W      (IDX_W)
    ) u_hash (
        .line_addr(req_line_addr),
        .seed     (sel_seed),
        .idx      (lk_idx)
    );

    // Response register: capture path on request, valid follows request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_l3_bank <= '0;
            rsp_l4_bank <= '0;
            rsp_bypass  <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_l3_bank <= sel_l3;
                rsp_l4_bank <= sel_l4v ? sel_l4 : '0;
                rsp_bypass  <= ~sel_l4v;
            end
        end
    end
endmodule

// File: rtl/class_bank_mapper_chk.sv
// Temporal checks on the mapper's ports, attached by bind below.
module class_bank_mapper_chk #(
    parameter int BANK_W = 6,
    parameter int IDX_W  = 3,
    parameter int CFG_AW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              cfg_we,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [BANK_W-1:0] cfg_wdata,
    input logic [BANK_W-1:0] cfg_rdata,
    input logic              swap_valid,
    input logic              rsp_valid,
    input logic [BANK_W-1:0] rsp_l3_bank,
    input logic [BANK_W-1:0] rsp_l4_bank,
    input logic              rsp_bypass
);
    logic data_field;
    assign data_field = (cfg_addr[IDX_W+1] == 1'b0) && (cfg_addr[IDX_W+4:IDX_W+3] != 2'd3);

    p_rsp_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_no_rsp_without_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_bypass_zero_l4_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_bypass) |-> (rsp_l4_bank == '0));

    p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(rsp_l3_bank) && $stable(rsp_bypass)));

    p_write_readback_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && data_field && !swap_valid) |=>
            ((cfg_addr != $past(cfg_addr)) || (cfg_rdata == $past(cfg_wdata))));
endmodule

bind class_bank_mapper class_bank_mapper_chk #(
    .BANK_W(BANK_W),
    .IDX_W (IDX_W),
    .CFG_AW(CFG_AW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .swap_valid (swap_valid),
    .rsp_valid  (rsp_valid),
    .rsp_l3_bank(rsp_l3_bank),
    .rsp_l4_bank(rsp_l4_bank),
    .rsp_bypass (rsp_bypass)
);

// File: tb/tb_class_bank_mapper.sv
module tb_class_bank_mapper;
    localparam int LA = 34;
    localparam int NS = 8;
    localparam int BW = 6;
    localparam int IW = 3;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_class = '0;
    logic [LA-1:0] req_line_addr = '0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [BW-1:0] cfg_wdata = '0;
    logic [BW-1:0] cfg_rdata;
    logic          swap_valid = 1'b0;
    logic [1:0]    swap_class = '0;
    logic          rsp_valid;
    logic [BW-1:0] rsp_l3_bank;
    logic [BW-1:0] rsp_l4_bank;
    logic          rsp_bypass;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Requirement-level model, indexed by class and role (0 active).
    logic [BW-1:0] m_l3   [3][2][NS];
    logic [BW-1:0] m_l4   [3][2][NS];
    logic [IW-1:0] m_seed [3][2];
    logic          m_l4v  [3][2];

    always #5 clk = ~clk;

    class_bank_mapper dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_class(req_class), .req_line_addr(req_line_addr),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .swap_valid(swap_valid), .swap_class(swap_class),
        .rsp_valid(rsp_valid), .rsp_l3_bank(rsp_l3_bank),
        .rsp_l4_bank(rsp_l4_bank), .rsp_bypass(rsp_bypass)
    );

    function automatic [AW-1:0] mk_addr(input int cls, input int role, input int fld, input int slot);
        mk_addr = {2'(cls), 1'(role), 2'(fld), 3'(slot)};
    endfunction

    // Bit-wise formulation of the fold: line bit b lands on index bit b mod IW.
    function automatic [IW-1:0] exp_idx(input logic [LA-1:0] a, input logic [IW-1:0] s);
        logic [IW-1:0] r;
        r = s;
        for (int b = 0; b < LA; b++) r[b % IW] = r[b % IW] ^ a[b];
        return r;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input int cls, input int role, input int fld, input int slot, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = mk_addr(cls, role, fld, slot); cfg_wdata = BW'(data);
        @(negedge clk);
        cfg_we = 1'b0;
        if (cls < 3) begin
            if (fld == 0) m_l3[cls][role][slot] = BW'(data);
            if (fld == 1) m_l4[cls][role][slot] = BW'(data);
            if (fld == 2) begin m_seed[cls][role] = IW'(data); m_l4v[cls][role] = data[IW]; end
        end
    endtask

    function automatic int model_read(input int cls, input int role, input int fld, input int slot);
        if (cls > 2) return 0;
        case (fld)
            0: return int'(m_l3[cls][role][slot]);
            1: return int'(m_l4[cls][role][slot]);
            2: return int'({m_l4v[cls][role], m_seed[cls][role]});
            default: return 0;
        endcase
    endfunction

    task automatic cfg_check(input string req, input int cls, input int role, input int fld, input int slot);
        cfg_addr = mk_addr(cls, role, fld, slot);
        #1;
        check(req, $sformatf("read c%0d r%0d f%0d s%0d", cls, role, fld, slot),
              int'(cfg_rdata), model_read(cls, role, fld, slot));
    endtask

    function automatic void model_swap(input int cls);
        logic [BW-1:0] t;
        logic [IW-1:0] ts;
        logic tv;
        for (int s = 0; s < NS; s++) begin
            t = m_l3[cls][0][s]; m_l3[cls][0][s] = m_l3[cls][1][s]; m_l3[cls][1][s] = t;
            t = m_l4[cls][0][s]; m_l4[cls][0][s] = m_l4[cls][1][s]; m_l4[cls][1][s] = t;
        end
        ts = m_seed[cls][0]; m_seed[cls][0] = m_seed[cls][1]; m_seed[cls][1] = ts;
        tv = m_l4v[cls][0];  m_l4v[cls][0]  = m_l4v[cls][1];  m_l4v[cls][1]  = tv;
    endfunction

    // Compare a captured response against model values computed before the request edge.
    task automatic check_rsp(input string req, input int e_l3, input int e_l4, input int e_byp);
        check(req, "rsp_valid", int'(rsp_valid), 1);
        check(req, "l3 bank", int'(rsp_l3_bank), e_l3);
        check(req, "l4 bank", int'(rsp_l4_bank), e_l4);
        check(req, "bypass", int'(rsp_bypass), e_byp);
    endtask

    task automatic expect_of(input int rcls, input logic [LA-1:0] a,
                             output int e_l3, output int e_l4, output int e_byp);
        int cls;
        logic [IW-1:0] ix;
        cls = (rcls == 3) ? 2 : rcls;
        ix = exp_idx(a, m_seed[cls][0]);
        e_l3  = int'(m_l3[cls][0][ix]);
        e_l4  = m_l4v[cls][0] ? int'(m_l4[cls][0][ix]) : 0;
        e_byp = m_l4v[cls][0] ? 0 : 1;
    endtask

    task automatic lookup(input string req, input int rcls, input logic [LA-1:0] a);
        int e3, e4, eb;
        expect_of(rcls, a, e3, e4, eb);
        @(negedge clk);
        req_valid = 1'b1; req_class = 2'(rcls); req_line_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp(req, e3, e4, eb);
    endtask

    task automatic t_reset;
        check("R1", "rsp_valid after reset", int'(rsp_valid), 0);
        cfg_check("R1", 0, 0, 0, 5);
        cfg_check("R1", 1, 1, 1, 2);
        cfg_check("R1", 2, 0, 2, 0);
        lookup("R1", 0, 34'h1_2345_6789);
        check("R1", "bypass set at reset", int'(rsp_bypass), 1);
        @(negedge clk);
        check("R2", "rsp_valid drops when idle", int'(rsp_valid), 0);
    endtask

    task automatic t_program;
        for (int s = 0; s < NS; s++) begin
            cfg_write(0, 0, 0, s, 10 + s);
            cfg_write(0, 0, 1, s, 40 + s);
            cfg_write(1, 0, 0, s, (s < 4) ? 7 : 9);
            cfg_write(1, 0, 1, s, 20 + s);
            cfg_write(2, 0, 0, s, 30 + s);
            cfg_write(2, 0, 1, s, 50 + s);
        end
        cfg_write(0, 0, 2, 0, 8 | 5);
        cfg_write(1, 0, 2, 0, 3);
        cfg_write(2, 0, 2, 0, 8 | 6);
        for (int s = 0; s < NS; s += 3) begin
            cfg_check("R11", 0, 0, 0, s);
            cfg_check("R11", 1, 0, 1, s);
            cfg_check("R11", 2, 0, 0, s);
        end
        cfg_check("R7", 0, 0, 2, 4);
        cfg_check("R7", 1, 0, 2, 0);
    endtask

    task automatic t_lookups;
        for (int b = 0; b < LA; b += 5) lookup("R3", 0, LA'(1) << b);
        lookup("R3", 0, 34'h3_FFFF_FFFF);
        lookup("R3", 2, 34'h2_A5A5_1234);
        lookup("R4", 1, 34'h0_0000_0001);
        lookup("R4", 1, 34'h0_0000_0006);
        lookup("R4", 1, 34'h1_DEAD_BEEF);
        lookup("R6", 3, 34'h0_1357_9BDF);
        lookup("R6", 2, 34'h0_1357_9BDF);
        lookup("R6", 1, 34'h0_1357_9BDF);
    endtask

    task automatic t_bypass;
        lookup("R5", 0, 34'h0_0F0F_0F0F);
        check("R5", "L4 used for class 0", int'(rsp_bypass), 0);
        lookup("R5", 1, 34'h0_0F0F_0F0F);
        check("R5", "bypass for class 1", int'(rsp_bypass), 1);
    endtask

    task automatic t_shadow;
        for (int s = 0; s < NS; s++) begin
            cfg_write(2, 1, 0, s, 60 - s);
            cfg_write(2, 1, 1, s, 1 + s);
        end
        cfg_write(2, 1, 2, 0, 1);
        lookup("R8", 2, 34'h0_4444_0001);
        lookup("R8", 2, 34'h3_0000_7777);
        cfg_check("R8", 2, 0, 0, 1);
        cfg_check("R8", 2, 1, 0, 1);
    endtask

    task automatic t_swap;
        @(negedge clk);
        swap_valid = 1'b1; swap_class = 2'd2;
        @(negedge clk);
        swap_valid = 1'b0;
        model_swap(2);
        cfg_check("R9", 2, 0, 0, 3);
        cfg_check("R9", 2, 1, 0, 3);
        cfg_check("R9", 2, 0, 2, 0);
        lookup("R9", 2, 34'h0_4444_0001);
        check("R9", "bypass after swap", int'(rsp_bypass), 1);
        lookup("R9", 0, 34'h0_4444_0001);
        lookup("R9", 1, 34'h0_4444_0001);
    endtask

    task automatic t_same_cycle;
        int e3, e4, eb;
        logic [LA-1:0] a;
        logic [IW-1:0] ix;
        a = 34'h0_00AB_CDEF;
        ix = exp_idx(a, m_seed[0][0]);
        expect_of(0, a, e3, e4, eb);
        @(negedge clk);
        req_valid = 1'b1; req_class = 2'd0; req_line_addr = a;
        cfg_we = 1'b1; cfg_addr = mk_addr(0, 0, 0, int'(ix)); cfg_wdata = 6'd63;
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
        m_l3[0][0][ix] = 6'd63;
        check_rsp("R10", e3, e4, eb);
        lookup("R10", 0, a);
        check("R10", "write visible next cycle", int'(rsp_l3_bank), 63);
        expect_of(2, a, e3, e4, eb);
        @(negedge clk);
        req_valid = 1'b1; req_class = 2'd2; req_line_addr = a;
        swap_valid = 1'b1; swap_class = 2'd2;
        @(negedge clk);
        req_valid = 1'b0; swap_valid = 1'b0;
        check_rsp("R10", e3, e4, eb);
        model_swap(2);
        lookup("R10", 2, a);
    endtask

    task automatic t_ignored;
        cfg_write(0, 0, 3, 2, 33);
        cfg_write(3, 0, 0, 2, 33);
        cfg_write(3, 1, 2, 0, 15);
        cfg_check("R7", 0, 0, 3, 2);
        cfg_check("R7", 3, 0, 0, 2);
        cfg_check("R7", 3, 1, 2, 0);
        for (int c = 0; c < 3; c++) begin
            for (int s = 0; s < NS; s++) cfg_check("R7", c, 0, 0, s);
            cfg_check("R7", c, 0, 2, 0);
        end
        lookup("R7", 0, 34'h0_0000_0009);
        lookup("R7", 2, 34'h0_0000_0009);
    endtask

    initial begin
        for (int c = 0; c < 3; c++)
            for (int r = 0; r < 2; r++) begin
                m_seed[c][r] = '0; m_l4v[c][r] = 1'b0;
                for (int s = 0; s < NS; s++) begin m_l3[c][r][s] = '0; m_l4[c][r][s] = '0; end
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_program;
        t_lookups;
        t_bypass;
        t_shadow;
        t_swap;
        t_same_cycle;
        t_ignored;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule